// File: doc/BRIEF.md
# Program-Overlay Memory with Front-Panel Override

This unit is a 16-bit-wide word memory for a small processor. Behind one read port sits a read/write RAM that covers the whole 12-bit address space. A read-only program store of 2048 words can be switched in over the upper half of that space, starting at address 0x800. While the program store is enabled, reads in that window return preloaded program words and writes there are dropped. Reads below 0x800 always go to RAM. A processor that holds a jump to 0x800 in RAM word 0 therefore enters the preloaded program straight after start-up.

Two complete sets of address, write-data and write-enable inputs reach the unit. One set comes from the processor and one from a front panel. When the manual enable is high, the front-panel set replaces the processor set for both reads and writes. This does not depend on whether the program store is enabled; that enable only decides which source answers in the upper window. With both enables low, the unit behaves as a plain 4096-word RAM.

The read path is registered so that FPGA block RAM can implement it. The word at the address presented at one rising clock edge appears on the output after that edge.

Top module: `mem_ovl_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `rd_data` is 0x0000 after that edge, whatever was read before.
- R2: `rd_data` shows, after a rising edge, the word stored at the effective address sampled at that edge (one cycle of read latency).
- R3: A write with the effective write-enable high stores the effective write data in RAM at the effective address on the rising edge. RAM starts with every word equal to 0x0000.
- R4: Addresses 0x000 to 0x7FF always read and write RAM, whatever the state of `prog_en`.
- R5: With `prog_en` high, a read at address A in 0x800 to 0xFFF returns program word n = A - 0x800.
- R6: With `prog_en` low, addresses 0x800 to 0xFFF read and write RAM like any other address.
- R7: With `prog_en` high, a write to 0x800 to 0xFFF is ignored. The RAM word there keeps its old value, which can be seen by reading it after `prog_en` is lowered.
- R8: With `man_en` high, the `man_*` inputs supply the address, write data and write enable. The `cpu_*` inputs, including `cpu_we`, have no effect.
- R9: With `man_en` high, `prog_en` still selects the program store for manual reads in the upper window.
- R10: Program word n equals ((n * 0x0101) mod 2^16) XOR 0xA5C3 for n < 64, and 0x0000 for 64 <= n < 2048.
- R11: A read and a write to the same RAM address at the same edge return the word held before the write (read-first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the read path |
| prog_en | input | 1 | Enables the program store over 0x800 to 0xFFF |
| man_en | input | 1 | Gives the front-panel input set control of the memory |
| man_addr | input | 12 | Front-panel word address |
| man_wdata | input | 16 | Front-panel write data |
| man_we | input | 1 | Front-panel write enable |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| rd_data | output | 16 | Registered read data |

## Verification
The hardest case to show from the ports is that a write blocked in the program window really left RAM untouched. While the store is enabled, that RAM word cannot be read at all. The stimulus first writes a known value to a high address with `prog_en` low. It then tries an overwrite with `prog_en` high, lowers `prog_en` and reads the word back. Throughout, the inactive input set is driven with a different address, inverted data and its write enable held high, so any leak from the wrong set corrupts the reference model's view of RAM and shows up on a later read.

// File: rtl/mem_ovl_pkg.sv
package mem_ovl_pkg;

  localparam int WORD_W = 16;

  typedef enum logic {
    RD_FROM_RAM  = 1'b0,
    RD_FROM_PROG = 1'b1
  } rd_src_e;

  // Preloaded program image: a short computed pattern, zero beyond the used length.
  function automatic logic [WORD_W-1:0] prog_word(input int unsigned n, input int unsigned used);
    logic [WORD_W-1:0] v;
    v = WORD_W'(n);
    if (n < used) return (v * 16'h0101) ^ 16'hA5C3;
    return '0;
  endfunction

endpackage

// File: rtl/ovl_src_mux.sv
module ovl_src_mux #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          man_en,
  input  logic [AW-1:0] man_addr,
  input  logic [DW-1:0] man_wdata,
  input  logic          man_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  output logic [AW-1:0] eff_addr,
  output logic [DW-1:0] eff_wdata,
  output logic          eff_we
);

  // The front panel wins outright; nothing of the processor set leaks through.
  always_comb begin
    if (man_en) begin
      eff_addr  = man_addr;
      eff_wdata = man_wdata;
      eff_we    = man_we;
    end else begin
      eff_addr  = cpu_addr;
      eff_wdata = cpu_wdata;
      eff_we    = cpu_we;
    end
  end

endmodule

// File: rtl/ovl_decode.sv
module ovl_decode #(
  parameter int AW        = 12,
  parameter int PROG_AW   = 11,
  parameter int PROG_BASE = 2048
) (
  input  logic               prog_en,
  input  logic [AW-1:0]      eff_addr,
  input  logic               eff_we,
  output logic               win_hit,
  output logic               ram_wr,
  output logic [PROG_AW-1:0] prog_idx
);

  localparam int PROG_DEPTH = 1 << PROG_AW;

  logic [AW:0] offset;
  logic        in_window;

  // Offset from the window base; the top bit flags an address below the base.
  assign offset    = {1'b0, eff_addr} - (AW+1)'(PROG_BASE);
  assign in_window = !offset[AW] && (offset < (AW+1)'(PROG_DEPTH));
  assign win_hit   = prog_en && in_window;
  assign prog_idx  = offset[PROG_AW-1:0];

  // Writes that land on the enabled program window are dropped.
  assign ram_wr    = eff_we && !win_hit;

endmodule

// File: rtl/ovl_ram.sv
module ovl_ram #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Read-first output register with synchronous reset.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= mem[addr];
  end

endmodule

// File: rtl/ovl_prog_rom.sv
module ovl_prog_rom
  import mem_ovl_pkg::*;
#(
  parameter int PROG_AW   = 11,
  parameter int DW        = 16,
  parameter int INIT_USED = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PROG_AW-1:0] idx,
  output logic [DW-1:0]      q
);

  localparam int DEPTH = 1 << PROG_AW;

  logic [DW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = DW'(prog_word(i, INIT_USED));
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= rom[idx];
  end

endmodule

// File: rtl/mem_ovl_unit.sv
module mem_ovl_unit
  import mem_ovl_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = WORD_W,
  parameter int PROG_AW   = 11,
  parameter int PROG_BASE = 2048,
  parameter int PROG_USED = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_en,
  input  logic          man_en,
  input  logic [AW-1:0] man_addr,
  input  logic [DW-1:0] man_wdata,
  input  logic          man_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0]      eff_addr;
  logic [DW-1:0]      eff_wdata;
  logic               eff_we;
  logic               win_hit;
  logic               ram_wr;
  logic [PROG_AW-1:0] prog_idx;
  logic [DW-1:0]      ram_q;
  logic [DW-1:0]      prog_q;
  rd_src_e            src_q;

  ovl_src_mux #(.AW(AW), .DW(DW)) u_mux (
    .man_en    (man_en),
    .man_addr  (man_addr),
    .man_wdata (man_wdata),
    .man_we    (man_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .eff_addr  (eff_addr),
    .eff_wdata (eff_wdata),
    .eff_we    (eff_we)
  );

  ovl_decode #(.AW(AW), .PROG_AW(PROG_AW), .PROG_BASE(PROG_BASE)) u_dec (
    .prog_en  (prog_en),
    .eff_addr (eff_addr),
    .eff_we   (eff_we),
    .win_hit  (win_hit),
    .ram_wr   (ram_wr),
    .prog_idx (prog_idx)
  );

  ovl_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .addr  (eff_addr),
    .wdata (eff_wdata),
    .we    (ram_wr),
    .q     (ram_q)
  );

  ovl_prog_rom #(.PROG_AW(PROG_AW), .DW(DW), .INIT_USED(PROG_USED)) u_rom (
    .clk (clk),
    .rst (rst),
    .idx (prog_idx),
    .q   (prog_q)
  );

  // Source choice travels with the read so it lines up with the array outputs.
  always_ff @(posedge clk) begin
    if (rst) src_q <= RD_FROM_RAM;
    else     src_q <= win_hit ? RD_FROM_PROG : RD_FROM_RAM;
  end

  assign rd_data = (src_q == RD_FROM_PROG) ? prog_q : ram_q;

endmodule

// File: rtl/mem_ovl_chk.sv
module mem_ovl_chk
  import mem_ovl_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int PROG_AW   = 11,
  parameter int PROG_BASE = 2048,
  parameter int PROG_USED = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          prog_en,
  input logic          man_en,
  input logic [AW-1:0] man_addr,
  input logic          man_we,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_we,
  input logic          ram_wr,
  input logic [DW-1:0] rd_data
);

  localparam logic [AW-1:0] BASE_A = AW'(PROG_BASE);

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: the edge after a reset edge leaves a zero output
  always @(posedge clk) begin
    if (rst_seen) p_reset_zero_r1: assert (rd_data == '0);
  end

  // R4: a processor write below the window always reaches RAM
  p_low_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!man_en && cpu_we && cpu_addr < BASE_A) |-> ram_wr);

  // R5: processor read in the enabled window returns the program word
  p_prog_read_r5: assert property (@(posedge clk) disable iff (rst)
    (!man_en && prog_en && cpu_addr >= BASE_A) |=>
      rd_data == DW'(prog_word(int'($past(cpu_addr) - BASE_A), PROG_USED)));

  // R7: no RAM write is issued into the enabled window
  p_window_write_blocked_r7: assert property (@(posedge clk) disable iff (rst)
    (!man_en && prog_en && cpu_addr >= BASE_A) |-> !ram_wr);

  // R8: with the panel in control, the processor write enable is ignored
  p_cpu_we_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (man_en && !man_we) |-> !ram_wr);

  // R9: manual read in the enabled window returns the program word
  p_manual_prog_read_r9: assert property (@(posedge clk) disable iff (rst)
    (man_en && prog_en && man_addr >= BASE_A) |=>
      rd_data == DW'(prog_word(int'($past(man_addr) - BASE_A), PROG_USED)));

endmodule

bind mem_ovl_unit mem_ovl_chk #(
  .AW(AW), .DW(DW), .PROG_AW(PROG_AW), .PROG_BASE(PROG_BASE), .PROG_USED(PROG_USED)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .prog_en  (prog_en),
  .man_en   (man_en),
  .man_addr (man_addr),
  .man_we   (man_we),
  .cpu_addr (cpu_addr),
  .cpu_we   (cpu_we),
  .ram_wr   (ram_wr),
  .rd_data  (rd_data)
);

// File: tb/sim_mem_ovl_unit.sv
module sim_mem_ovl_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_en = 1'b0;
  logic        man_en = 1'b0;
  logic [11:0] man_addr = '0;
  logic [15:0] man_wdata = '0;
  logic        man_we = 1'b0;
  logic [11:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [15:0] model [4096];
  int          q_due [$];
  logic [15:0] q_exp [$];
  string       q_req [$];

  always #10 clk = ~clk;  // 50 MHz

  mem_ovl_unit u0 (
    .clk(clk), .rst(rst), .prog_en(prog_en), .man_en(man_en),
    .man_addr(man_addr), .man_wdata(man_wdata), .man_we(man_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
    .rd_data(rd_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Program image as the requirements define it (R10).
  function automatic logic [15:0] exp_prog(input int n);
    logic [15:0] v;
    v = 16'(n);
    if (n < 64) return (v * 16'h0101) ^ 16'hA5C3;
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compares each queued expectation in its due cycle.
  always @(negedge clk) begin
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      check(q_req[0], rd_data, q_exp[0]);
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_req.pop_front());
    end
  end

  // Driver: one access; the idle input set carries junk with its write enable high.
  task automatic step(input bit man, input bit pe, input logic [11:0] a,
                      input logic [15:0] d, input bit we, input string req);
    logic hit;
    @(negedge clk);
    prog_en = pe;
    man_en  = man;
    if (man) begin
      man_addr = a;  man_wdata = d;  man_we = we;
      cpu_addr = a ^ 12'h3A5;  cpu_wdata = ~d;  cpu_we = 1'b1;
    end else begin
      cpu_addr = a;  cpu_wdata = d;  cpu_we = we;
      man_addr = a ^ 12'h5C3;  man_wdata = ~d;  man_we = 1'b1;
    end
    hit = pe && a[11];
    q_due.push_back(cyc + 1);
    q_exp.push_back(hit ? exp_prog(int'(a[10:0])) : model[a]);  // read-first (R11)
    q_req.push_back(req);
    if (we && !hit) model[a] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    man_en = 1'b0; man_we = 1'b0; cpu_we = 1'b0; prog_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected finish before timeout");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1 reset output", rd_data, 16'h0000);
    rst = 1'b0;

    // R3 / R2: fresh RAM reads zero, writes land and read back next cycle
    step(0, 0, 12'h010, 16'h0000, 0, "R3 initial zero");
    step(0, 0, 12'h010, 16'h1234, 1, "R3 write");
    step(0, 0, 12'h011, 16'hBEEF, 1, "R3 write");
    step(0, 0, 12'h010, 16'h0000, 0, "R2 readback");
    step(0, 0, 12'h011, 16'h0000, 0, "R2 readback");
    step(0, 0, 12'h000, 16'hA800, 1, "R3 word0 jump");
    step(0, 0, 12'h000, 16'h0000, 0, "R2 word0 readback");

    // R11: same-address read and write give the old word
    step(0, 0, 12'h010, 16'h5555, 1, "R11 read-first");
    step(0, 0, 12'h010, 16'h0000, 0, "R11 new word");

    // R5 / R10: program window contents
    step(0, 1, 12'h800, 16'h0000, 0, "R5 word 0");
    step(0, 1, 12'h801, 16'h0000, 0, "R5 word 1");
    step(0, 1, 12'h83F, 16'h0000, 0, "R10 last used word");
    step(0, 1, 12'h840, 16'h0000, 0, "R10 first zero word");
    step(0, 1, 12'hFFF, 16'h0000, 0, "R10 top word");

    // R4: low RAM unaffected by prog_en
    step(0, 1, 12'h7FF, 16'hC0DE, 1, "R4 write at window edge");
    step(0, 1, 12'h7FF, 16'h0000, 0, "R4 read at window edge");
    step(0, 1, 12'h011, 16'h0000, 0, "R4 low read");

    // R6: high addresses are RAM when the window is off
    step(0, 0, 12'h805, 16'h7777, 1, "R6 high write");
    step(0, 0, 12'h900, 16'h9009, 1, "R6 high write");
    step(0, 0, 12'h900, 16'h0000, 0, "R6 high read");

    // R7: window write is dropped, old RAM word survives
    step(0, 1, 12'h805, 16'hDEAD, 1, "R7 blocked write");
    step(0, 1, 12'h805, 16'h0000, 0, "R7 window still program");
    step(0, 0, 12'h805, 16'h0000, 0, "R7 RAM unchanged");

    // R8: panel takes over; processor set (we high, other address) ignored
    step(1, 0, 12'h020, 16'hFACE, 1, "R8 manual write");
    step(1, 0, 12'h020, 16'h0000, 0, "R8 manual read");
    step(0, 0, 12'h020 ^ 12'h3A5, 16'h0000, 0, "R8 cpu write ignored");
    step(0, 0, 12'h020, 16'h0000, 0, "R8 visible to cpu");

    // R9: manual reads still see the program window
    step(1, 1, 12'h802, 16'h0000, 0, "R9 manual program read");
    step(1, 1, 12'h900, 16'hFFFF, 1, "R9 manual window write blocked");
    step(1, 0, 12'h900, 16'h0000, 0, "R9 manual RAM read");

    // R1: reset mid-run clears the output
    step(0, 0, 12'h011, 16'h0000, 0, "R2 pre-reset read");
    idle();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", rd_data, 16'h0000);
    rst = 1'b0;
    step(0, 0, 12'h011, 16'h0000, 0, "R3 RAM kept over reset");
    idle();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule